// File: doc/BRIEF.md
# Synchronous SRAM access controller

This block arbitrates between five internal requesters (a TDM port, a transmit segmenter, a receive reassembler, a cell interface and a host port) for one external synchronous SRAM array. The array has up to two banks, and each bank is 36 bits wide: four byte lanes, each with a ninth flag bit. Every request is a byte-addressed read or write, and each one becomes a single-cycle, single-word access. Bursts are never issued.

A 21-bit request address is split into three parts. The top bit picks the bank. The middle bits form the word address, of which only the parameterised bank depth is significant. The two low bits pick a byte lane. Writes drive all pin signals in the same cycle as the address. Reads return their word a programmable 1 to 3 cycles after the address cycle. A small tag pipeline routes the returned word back to the requester that issued the read, so a new access can start every cycle.

Top module: `sram_ctrl`

## Requirements
- R1: The cycle after a grant, `mem_cs_no[b]` is low for bank b = addr[20], the other select is high, and `mem_addr_o` equals addr[2+BANK_AW-1:2]. Address bits above that range and below bit 20 are ignored.
- R2: A word write (`word_i`=1) drives all four `mem_we_no` low and `mem_dq_oe_o` high for one cycle. Lane l of `mem_dq_o` carries wdata[8l+7:8l] on bits [9l+7:9l] and wflag[l] on bit 9l+8.
- R3: A byte write (`word_i`=0) drives only `mem_we_no[addr[1:0]]` low. That lane carries wdata[7:0] and wflag[0]. Other lanes and their flags in memory keep their values.
- R4: A read cycle has one bank select low, all four `mem_we_no` high and `mem_dq_oe_o` low.
- R5: With `rd_lat_i` = L in {1,2,3}, `mem_oe_no` is low exactly in the L-th cycle after the read's address cycle, which is when the word is sampled from `mem_dq_i`. In the next cycle the issuing requester's `rvalid_o` bit pulses for one cycle. At that time `rdata_o` and `rflag_o` hold the sampled lanes, unpacked with the R2 layout.
- R6: `gnt_o` responds combinationally in the request cycle. It has at most one bit set, and that bit belongs to the lowest-index eligible requester. A requester holds its request until it is granted.
- R7: Reads can be granted in consecutive cycles. Their data returns in issue order, one return per cycle.
- R8: A write is not granted in a cycle whose following cycle is a read-data return cycle. Reads are granted as usual in that cycle. `mem_dq_oe_o` is never high while `mem_oe_no` is low.
- R9: In the cycle after a cycle with no grant, both bank selects are high, all write strobes are high and `mem_dq_oe_o` is low.
- R10: During reset, the pin outputs are idle (selects and strobes high, bus released, `mem_oe_no` high) and `rvalid_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_lat_i | input | 2 | Read-return delay in cycles (1 to 3) |
| req_i | input | N_REQ | Request per requester, index 0 highest priority |
| we_i | input | N_REQ | 1 = write, 0 = read |
| word_i | input | N_REQ | 1 = whole word write, 0 = single byte write |
| addr_i | input | N_REQ x 21 | Byte address per requester |
| wdata_i | input | N_REQ x 32 | Write data per requester |
| wflag_i | input | N_REQ x 4 | Write flag bits per requester |
| gnt_o | output | N_REQ | One-hot grant, same cycle as request |
| rvalid_o | output | N_REQ | Read-return pulse to the issuing requester |
| rdata_o | output | 32 | Returned read data |
| rflag_o | output | 4 | Returned flag bits |
| mem_cs_no | output | 2 | Bank selects, active low |
| mem_addr_o | output | BANK_AW | Word address |
| mem_we_no | output | 4 | Byte-lane write strobes, active low |
| mem_oe_no | output | 1 | Output enable, low in read-data cycles |
| mem_dq_o | output | 36 | Write data bus to memory |
| mem_dq_oe_o | output | 1 | Drive enable for `mem_dq_o` |
| mem_dq_i | input | 36 | Read data bus from memory |

## Verification
The controller runs against a behavioural memory model at each of the three read delays.

- **Light random mixed traffic** over a small address pool. Word and byte writes overlay each other, and the ignored high address bits change at random. This separates correct lane masking and address truncation from stray lane or alias corruption.
- **Saturated traffic** from all five requesters at once. This separates fixed priority from any fair or stale grant, and it catches writes that are granted into a return cycle.
- **A single requester streaming reads every cycle.** This shows whether in-flight tags are kept and returned in order.
- **Drained idle stretches** between delay changes. These check the idle pin state.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned LANES      = DATA_W / BYTE_W;
  localparam int unsigned LANE_W     = BYTE_W + 1;
  localparam int unsigned DQ_W       = LANES * LANE_W;
  localparam int unsigned LANE_SEL_W = $clog2(LANES);
  localparam int unsigned N_BANKS    = 2;
  localparam int unsigned MAX_LAT    = 3;
  localparam int unsigned LAT_W      = $clog2(MAX_LAT + 1);
endpackage

// File: rtl/sram_arb.sv
`timescale 1ns/1ps
module sram_arb #(
  parameter  int unsigned N_REQ = 5,
  localparam int unsigned IDX_W = $clog2(N_REQ)
) (
  input  logic [N_REQ-1:0] req_i,
  input  logic [N_REQ-1:0] we_i,
  input  logic             wr_block_i,
  output logic [N_REQ-1:0] gnt_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  logic [N_REQ-1:0] elig;

  // writes sit out a cycle whose address slot collides with read return
  assign elig = req_i & ~(we_i & {N_REQ{wr_block_i}});

  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    any_o = 1'b0;
    for (int i = int'(N_REQ) - 1; i >= 0; i--) begin
      if (elig[i]) begin
        gnt_o    = '0;
        gnt_o[i] = 1'b1;
        idx_o    = IDX_W'(i);
        any_o    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sram_addr_map.sv
`timescale 1ns/1ps
module sram_addr_map
  import sram_ctrl_pkg::*;
#(
  parameter  int unsigned ADDR_W   = 21,
  parameter  int unsigned BANK_AW  = 18,
  localparam int unsigned BANK_BIT = ADDR_W - 1,
  localparam int unsigned WORD_LSB = LANE_SEL_W
) (
  input  logic               act_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               we_i,
  input  logic               word_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [LANES-1:0]   wflag_i,
  output logic [N_BANKS-1:0] cs_n_o,
  output logic [BANK_AW-1:0] waddr_o,
  output logic [LANES-1:0]   we_n_o,
  output logic [DQ_W-1:0]    dq_o,
  output logic               drive_o
);
  logic [LANE_SEL_W-1:0] lane;

  assign lane    = addr_i[LANE_SEL_W-1:0];
  assign waddr_o = addr_i[WORD_LSB +: BANK_AW];
  assign drive_o = act_i & we_i;

  always_comb begin
    cs_n_o = '1;
    if (act_i) cs_n_o[addr_i[BANK_BIT]] = 1'b0;
  end

  always_comb begin
    we_n_o = '1;
    if (act_i && we_i) begin
      if (word_i) we_n_o = '0;
      else        we_n_o[lane] = 1'b0;
    end
  end

  // byte writes replicate byte 0 onto every lane; strobes pick the target
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign dq_o[l*LANE_W +: LANE_W] = word_i
        ? {wflag_i[l], wdata_i[l*BYTE_W +: BYTE_W]}
        : {wflag_i[0], wdata_i[BYTE_W-1:0]};
  end

  if (WORD_LSB + BANK_AW < BANK_BIT) begin : g_hi_unused
    logic unused_hi;
    assign unused_hi = ^addr_i[BANK_BIT-1:WORD_LSB+BANK_AW];
  end
endmodule

// File: rtl/sram_rd_track.sv
`timescale 1ns/1ps
module sram_rd_track
  import sram_ctrl_pkg::*;
#(
  parameter  int unsigned N_REQ = 5,
  localparam int unsigned IDX_W = $clog2(N_REQ)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LAT_W-1:0] lat_i,
  input  logic             push_i,
  input  logic [IDX_W-1:0] push_id_i,
  input  logic [DQ_W-1:0]  mem_dq_i,
  output logic             wr_block_o,
  output logic             due_o,
  output logic [N_REQ-1:0] rvalid_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [LANES-1:0] rflag_o
);
  logic [LAT_W-1:0] lat_eff;
  logic [MAX_LAT:0] stg_v;
  logic [IDX_W-1:0] stg_id [MAX_LAT+1];
  logic [DATA_W-1:0] rd_bytes;
  logic [LANES-1:0]  rd_flags;

  // reserved value 0 behaves as 1
  assign lat_eff = (lat_i == '0) ? LAT_W'(1) : lat_i;

  // stage s holds the read whose address cycle was s cycles ago
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_v <= '0;
      for (int s = 0; s <= int'(MAX_LAT); s++) stg_id[s] <= '0;
    end else begin
      stg_v[0]  <= push_i;
      stg_id[0] <= push_id_i;
      for (int s = 1; s <= int'(MAX_LAT); s++) begin
        stg_v[s]  <= stg_v[s-1];
        stg_id[s] <= stg_id[s-1];
      end
    end
  end

  assign due_o      = stg_v[lat_eff];
  assign wr_block_o = stg_v[lat_eff - LAT_W'(1)];

  for (genvar l = 0; l < LANES; l++) begin : g_unpack
    assign rd_bytes[l*BYTE_W +: BYTE_W] = mem_dq_i[l*LANE_W +: BYTE_W];
    assign rd_flags[l]                  = mem_dq_i[l*LANE_W + BYTE_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= '0;
      rdata_o  <= '0;
      rflag_o  <= '0;
    end else begin
      rvalid_o <= '0;
      if (due_o) begin
        rvalid_o[stg_id[lat_eff]] <= 1'b1;
        rdata_o <= rd_bytes;
        rflag_o <= rd_flags;
      end
    end
  end

  // R5
  ret_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    due_o |=> $onehot(rvalid_o));
  // R5
  no_ret_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !due_o |=> (rvalid_o == '0));
  // R7
  stream_ret_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (due_o && stg_v[lat_eff - LAT_W'(1)]) |=> due_o);
endmodule

// File: rtl/sram_ctrl.sv
`timescale 1ns/1ps
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter  int unsigned N_REQ   = 5,
  parameter  int unsigned ADDR_W  = 21,
  parameter  int unsigned BANK_AW = 18,
  localparam int unsigned IDX_W   = $clog2(N_REQ)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [LAT_W-1:0]                rd_lat_i,
  input  logic [N_REQ-1:0]                req_i,
  input  logic [N_REQ-1:0]                we_i,
  input  logic [N_REQ-1:0]                word_i,
  input  logic [N_REQ-1:0][ADDR_W-1:0]    addr_i,
  input  logic [N_REQ-1:0][DATA_W-1:0]    wdata_i,
  input  logic [N_REQ-1:0][LANES-1:0]     wflag_i,
  output logic [N_REQ-1:0]                gnt_o,
  output logic [N_REQ-1:0]                rvalid_o,
  output logic [DATA_W-1:0]               rdata_o,
  output logic [LANES-1:0]                rflag_o,
  output logic [N_BANKS-1:0]              mem_cs_no,
  output logic [BANK_AW-1:0]              mem_addr_o,
  output logic [LANES-1:0]                mem_we_no,
  output logic                            mem_oe_no,
  output logic [DQ_W-1:0]                 mem_dq_o,
  output logic                            mem_dq_oe_o,
  input  logic [DQ_W-1:0]                 mem_dq_i
);
  logic [IDX_W-1:0]   sel;
  logic               any_gnt, wr_block, due;
  logic [N_BANKS-1:0] cs_n_d;
  logic [BANK_AW-1:0] waddr_d;
  logic [LANES-1:0]   we_n_d;
  logic [DQ_W-1:0]    dq_d;
  logic               drive_d;

  sram_arb #(.N_REQ(N_REQ)) u_arb (
    .req_i      (req_i),
    .we_i       (we_i),
    .wr_block_i (wr_block),
    .gnt_o      (gnt_o),
    .idx_o      (sel),
    .any_o      (any_gnt)
  );

  sram_addr_map #(.ADDR_W(ADDR_W), .BANK_AW(BANK_AW)) u_map (
    .act_i   (any_gnt),
    .addr_i  (addr_i[sel]),
    .we_i    (we_i[sel]),
    .word_i  (word_i[sel]),
    .wdata_i (wdata_i[sel]),
    .wflag_i (wflag_i[sel]),
    .cs_n_o  (cs_n_d),
    .waddr_o (waddr_d),
    .we_n_o  (we_n_d),
    .dq_o    (dq_d),
    .drive_o (drive_d)
  );

  sram_rd_track #(.N_REQ(N_REQ)) u_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lat_i      (rd_lat_i),
    .push_i     (any_gnt & ~we_i[sel]),
    .push_id_i  (sel),
    .mem_dq_i   (mem_dq_i),
    .wr_block_o (wr_block),
    .due_o      (due),
    .rvalid_o   (rvalid_o),
    .rdata_o    (rdata_o),
    .rflag_o    (rflag_o)
  );

  // pin stage: one register between grant and the SRAM
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_cs_no   <= '1;
      mem_addr_o  <= '0;
      mem_we_no   <= '1;
      mem_dq_o    <= '0;
      mem_dq_oe_o <= 1'b0;
    end else begin
      mem_cs_no   <= cs_n_d;
      mem_addr_o  <= waddr_d;
      mem_we_no   <= we_n_d;
      mem_dq_o    <= dq_d;
      mem_dq_oe_o <= drive_d;
    end
  end

  assign mem_oe_no = ~due;

  // R8
  bus_clash_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> mem_oe_no);
  // R4
  read_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mem_cs_no != '1) && (mem_we_no == '1)) |-> !mem_dq_oe_o);
  // R2
  wr_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_no != '1) |-> (mem_dq_oe_o && (mem_cs_no != '1)));
  // R3
  strobe_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_no != '1) |-> ($countones(~mem_we_no) == 1 || mem_we_no == '0));
  // R1
  one_bank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~mem_cs_no) <= 1);
  // R6
  gnt_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~req_i) == '0);
  // R6
  gnt_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  // R9
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o == '0) |=> (mem_cs_no == '1 && mem_we_no == '1 && !mem_dq_oe_o));
endmodule

// File: tb/sram_ctrl_bench.sv
`timescale 1ns/1ps
module sram_ctrl_bench;
  localparam int unsigned N   = 5;
  localparam int unsigned AW  = 21;
  localparam int unsigned BAW = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] lat;
  logic [N-1:0] req, we, word, gnt, rvalid;
  logic [N-1:0][AW-1:0] addr;
  logic [N-1:0][31:0] wdata;
  logic [N-1:0][3:0] wflag;
  logic [31:0] rdata;
  logic [3:0] rflag, we_n;
  logic [1:0] cs_n;
  logic [BAW-1:0] maddr;
  logic oe_n, dq_oe;
  logic [35:0] dq_o, dq_i;

  always #10 clk = ~clk;

  sram_ctrl #(.N_REQ(N), .ADDR_W(AW), .BANK_AW(BAW)) u_sram_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .rd_lat_i(lat), .req_i(req), .we_i(we),
    .word_i(word), .addr_i(addr), .wdata_i(wdata), .wflag_i(wflag),
    .gnt_o(gnt), .rvalid_o(rvalid), .rdata_o(rdata), .rflag_o(rflag),
    .mem_cs_no(cs_n), .mem_addr_o(maddr), .mem_we_no(we_n), .mem_oe_no(oe_n),
    .mem_dq_o(dq_o), .mem_dq_oe_o(dq_oe), .mem_dq_i(dq_i)
  );

  // behavioural synchronous SRAM with selectable read pipeline
  logic [35:0] mm [int];
  logic        rp_v [1:3];
  logic [35:0] rp_d [1:3];
  always @(posedge clk) begin : mem_model
    int k;
    logic [35:0] cur;
    logic rd;
    rd = 1'b0;
    cur = '0;
    if (cs_n != 2'b11) begin
      k = int'({~cs_n[1], maddr});
      cur = mm.exists(k) ? mm[k] : 36'h0;
      if (we_n == 4'hf) rd = 1'b1;
      else begin
        for (int l = 0; l < 4; l++) if (!we_n[l]) cur[9*l +: 9] = dq_o[9*l +: 9];
        mm[k] = cur;
      end
    end
    if (!rst_n) begin
      for (int s = 1; s <= 3; s++) rp_v[s] <= 1'b0;
    end else begin
      rp_v[1] <= rd;
      rp_d[1] <= cur;
      for (int s = 2; s <= 3; s++) begin
        rp_v[s] <= rp_v[s-1];
        rp_d[s] <= rp_d[s-1];
      end
    end
  end
  assign dq_i = rp_v[lat] ? rp_d[lat] : 36'h0;

  int n_cmp, n_bad, it;
  bit done;

  task automatic chk(string t, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h (iter %0d)", t, act, exp, it);
    end
  endtask

  // golden memory and per-iteration expectations
  logic [35:0] gm [int];
  logic        ex_v [16];
  int          ex_kind [16];
  logic [1:0]  ex_cs [16];
  logic [BAW-1:0] ex_ad [16];
  logic [3:0]  ex_we [16];
  logic [35:0] ex_dq [16], ex_mk [16];
  logic        ret_due [16];
  logic [N-1:0] rv_oh [16];
  logic [35:0] rv_d [16];

  logic          p_v [N];
  logic          p_we [N], p_word [N];
  logic [AW-1:0] p_addr [N];
  logic [31:0]   p_wd [N];
  logic [3:0]    p_wf [N];

  function automatic int key_of(logic [AW-1:0] a);
    return int'({a[AW-1], a[2 +: BAW]});
  endfunction

  function automatic logic [35:0] unpack(logic [35:0] w);
    logic [35:0] r;
    for (int l = 0; l < 4; l++) begin
      r[8*l +: 8] = w[9*l +: 8];
      r[32 + l]   = w[9*l + 8];
    end
    return r;
  endfunction

  task automatic new_op(int i, bit rd_only);
    p_v[i]    = 1'b1;
    p_we[i]   = rd_only ? 1'b0 : 1'($urandom_range(0, 1));
    p_word[i] = 1'($urandom_range(0, 1));
    p_addr[i] = {1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
                 16'($urandom_range(0, 5)), 2'($urandom_range(0, 3))};
    p_wd[i]   = $urandom;
    p_wf[i]   = 4'($urandom_range(0, 15));
  endtask

  task automatic check_slot(int s);
    string t;
    if (ex_v[s]) begin
      t = (ex_kind[s] == 0) ? "R4 read" : (ex_kind[s] == 1) ? "R2 word" : "R3 byte";
      chk({"R1 ", t, " cs_n"}, 64'(cs_n), 64'(ex_cs[s]));
      chk({"R1 ", t, " addr"}, 64'(maddr), 64'(ex_ad[s]));
      chk({t, " we_n"}, 64'(we_n), 64'(ex_we[s]));
      chk({t, " dq_oe"}, 64'(dq_oe), 64'(ex_kind[s] != 0));
      if (ex_kind[s] != 0) chk({t, " dq"}, 64'(dq_o & ex_mk[s]), 64'(ex_dq[s] & ex_mk[s]));
    end else begin
      chk("R9 idle cs_n", 64'(cs_n), 64'h3);
      chk("R9 idle we_n", 64'(we_n), 64'hf);
      chk("R9 idle dq_oe", 64'(dq_oe), 64'h0);
    end
    chk("R5 oe_n", 64'(oe_n), 64'(!ret_due[s]));
    chk("R5 R7 rvalid", 64'(rvalid), 64'(rv_oh[s]));
    if (rv_oh[s] != '0) chk("R5 rdata", 64'({rflag, rdata}), 64'(unpack(rv_d[s])));
    chk("R8 bus clash", 64'(dq_oe && rp_v[lat]), 64'h0);
    ex_v[s] = 1'b0; ret_due[s] = 1'b0; rv_oh[s] = '0;
  endtask

  task automatic step(int pct, int only, bit rd_only);
    logic [N-1:0] eg;
    logic blocked;
    int g, s, k;
    logic [35:0] cur, nd, mk;
    @(negedge clk);
    check_slot(it % 16);
    for (int i = 0; i < int'(N); i++)
      if (!p_v[i] && (only < 0 || only == i) && int'($urandom_range(0, 99)) < pct)
        new_op(i, rd_only);
    for (int i = 0; i < int'(N); i++) begin
      req[i] = p_v[i]; we[i] = p_we[i]; word[i] = p_word[i];
      addr[i] = p_addr[i]; wdata[i] = p_wd[i]; wflag[i] = p_wf[i];
    end
    #1;
    blocked = ret_due[(it + 1) % 16];
    eg = '0; g = -1;
    for (int i = 0; i < int'(N); i++)
      if (g < 0 && p_v[i] && !(p_we[i] && blocked)) begin eg[i] = 1'b1; g = i; end
    chk("R6 R8 gnt", 64'(gnt), 64'(eg));
    if (g >= 0) begin
      s = (it + 1) % 16;
      k = key_of(p_addr[g]);
      cur = gm.exists(k) ? gm[k] : 36'h0;
      ex_v[s]  = 1'b1;
      ex_cs[s] = p_addr[g][AW-1] ? 2'b01 : 2'b10;
      ex_ad[s] = p_addr[g][2 +: BAW];
      nd = '0; mk = '0;
      if (!p_we[g]) begin
        ex_kind[s] = 0; ex_we[s] = 4'hf;
        ret_due[(it + 1 + int'(lat)) % 16] = 1'b1;
        rv_oh[(it + 2 + int'(lat)) % 16] = eg;
        rv_d[(it + 2 + int'(lat)) % 16] = cur;
      end else if (p_word[g]) begin
        ex_kind[s] = 1; ex_we[s] = 4'h0;
        for (int l = 0; l < 4; l++) nd[9*l +: 9] = {p_wf[g][l], p_wd[g][8*l +: 8]};
        mk = '1;
        gm[k] = nd;
      end else begin
        ex_kind[s] = 2;
        ex_we[s] = ~(4'b1 << p_addr[g][1:0]);
        nd[9*p_addr[g][1:0] +: 9] = {p_wf[g][0], p_wd[g][7:0]};
        mk[9*p_addr[g][1:0] +: 9] = 9'h1ff;
        cur[9*p_addr[g][1:0] +: 9] = nd[9*p_addr[g][1:0] +: 9];
        gm[k] = cur;
      end
      ex_dq[s] = nd; ex_mk[s] = mk;
      p_v[g] = 1'b0;
    end
    it++;
  endtask

  initial begin
    void'($urandom(32'h5eed));
    n_cmp = 0; n_bad = 0; it = 0; done = 1'b0;
    rst_n = 1'b0; lat = 2'd1;
    req = '0; we = '0; word = '0; addr = '0; wdata = '0; wflag = '0;
    for (int s = 0; s < 16; s++) begin
      ex_v[s] = 1'b0; ret_due[s] = 1'b0; rv_oh[s] = '0; ex_kind[s] = 0;
    end
    for (int i = 0; i < int'(N); i++) p_v[i] = 1'b0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 cs_n", 64'(cs_n), 64'h3);
    chk("R10 we_n", 64'(we_n), 64'hf);
    chk("R10 dq_oe", 64'(dq_oe), 64'h0);
    chk("R10 oe_n", 64'(oe_n), 64'h1);
    chk("R10 rvalid", 64'(rvalid), 64'h0);
    chk("R10 gnt", 64'(gnt), 64'h0);
    rst_n = 1'b1;
    for (int l = 1; l <= 3; l++) begin
      lat = 2'(l);
      repeat (300) step(45, -1, 1'b0);  // mixed traffic
      repeat (40)  step(100, -1, 1'b0); // full contention
      repeat (30)  step(100, 2, 1'b1);  // R7 read stream
      repeat (40)  step(100, -1, 1'b0);
      repeat (12)  step(0, -1, 1'b0);   // drain before delay change
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired at iter %0d", it);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule